// File: doc/BRIEF.md
# Coalescing Word-Commit Store Buffer

This block queues stores from a core on their way to a data array that keeps check bits over whole aligned 32-bit words. That array can take a complete word in one write, but a store that covers only some bytes of a word forces it to read the old word, combine the bytes and recompute the check bits. The buffer cuts down on those slow writes. It folds narrow stores that land in the same aligned word into one pending entry, so that the entry often reaches a complete byte mask before it leaves.

Each store carries a word address, 32 data bits and a 4-bit byte-enable mask. A store may merge only into the youngest pending entry, and only while that entry's short merge window is still open. Entries leave strictly in arrival order through a valid/ready commit port. Each commit carries a flag telling the array whether the write is a direct full-word write or a partial write that needs read-modify-write handling.

Top module: `coalescing_store_buffer`

## Requirements
- R1: A store accepted while the youngest entry is open and holds the same word address is folded into that entry. Each enabled byte lane (lane b is data bits 8b+7..8b, enabled by mask bit b) is written, the mask becomes the OR of the two masks, and no entry is added.
- R2: When a merged store enables a lane that is already valid, the newer store's byte replaces the older one.
- R3: Entries are committed in the order they were allocated. Each commit presents the entry's word address, merged data and mask.
- R4: The buffer holds at most 4 entries. With 4 entries held, st_ready is low for any store that cannot merge.
- R5: While cm_valid is high and cm_ready is low, cm_valid stays high and cm_addr, cm_data and cm_mask do not change.
- R6: cm_full is 1 when the presented mask is 4'hF and 0 for any other mask.
- R7: An entry is open for merging during the 2 cycles after the clock edge that allocates it. A same-word store that arrives later allocates a new entry.
- R8: Once a store to a different word allocates behind an entry, that entry never merges again, even for its own word address.
- R9: An entry that is the only entry and still open is not presented. It is presented from the first cycle in which it is closed.
- R10: After reset the buffer is empty: cm_valid is 0 and st_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle |
| st_addr | input | 30 | Aligned word address of the store |
| st_data | input | 32 | Store data, lane b in bits 8b+7..8b |
| st_mask | input | 4 | Byte enables, bit b enables lane b |
| cm_valid | output | 1 | Head entry offered to the array |
| cm_ready | input | 1 | Array takes the offered entry |
| cm_addr | output | 30 | Word address of the offered entry |
| cm_data | output | 32 | Merged data of the offered entry |
| cm_mask | output | 4 | Merged byte mask of the offered entry |
| cm_full | output | 1 | 1 = full-word write, 0 = partial write |

## Verification
A store can merge into the youngest entry in the same cycle that the array takes a different, older entry from the head. One pointer moves while another entry's data and mask are being updated. The bench makes this happen with short runs of stores to a few word addresses while cm_ready toggles at random. Every cycle it compares st_ready, cm_valid and the whole commit payload against a queue-based model. That model pops, ages and merges its entries from the requirements alone, so a merge that lands in the wrong entry, or a commit that drops or repeats an entry, appears as a mismatch in that cycle.

// File: rtl/coalescing_store_buffer.sv
module coalescing_store_buffer #(
  parameter int AW     = 30,
  parameter int LANES  = 4,
  parameter int DEPTH  = 4,
  parameter int WINDOW = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               st_valid,
  output logic               st_ready,
  input  logic [AW-1:0]      st_addr,
  input  logic [8*LANES-1:0] st_data,
  input  logic [LANES-1:0]   st_mask,
  output logic               cm_valid,
  input  logic               cm_ready,
  output logic [AW-1:0]      cm_addr,
  output logic [8*LANES-1:0] cm_data,
  output logic [LANES-1:0]   cm_mask,
  output logic               cm_full
);
  localparam int DW = 8 * LANES;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int GW = $clog2(WINDOW + 1);
  localparam logic [GW-1:0] WIN  = GW'(WINDOW);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [LANES-1:0] mask_q [DEPTH];
  logic [GW-1:0]    age_q  [DEPTH];
  logic [PW-1:0]    head_q, tail_q;
  logic [CW-1:0]    cnt_q;

  wire [PW-1:0] yng      = tail_q - 1'b1;
  wire          yng_open = (cnt_q != '0) && (age_q[yng] < WIN);
  wire          hit      = st_valid && yng_open && (addr_q[yng] == st_addr);
  wire          alloc    = st_valid && !hit && (cnt_q != CAP);
  wire          pop      = cm_valid && cm_ready;

  assign st_ready = hit || (cnt_q != CAP);
  assign cm_valid = (cnt_q != '0) && !((cnt_q == CW'(1)) && yng_open);
  assign cm_addr  = addr_q[head_q];
  assign cm_data  = data_q[head_q];
  assign cm_mask  = mask_q[head_q];
  assign cm_full  = &mask_q[head_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop)   head_q <= head_q + 1'b1;
      if (alloc) tail_q <= tail_q + 1'b1;
      cnt_q <= cnt_q + CW'(alloc) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++)
      if (age_q[i] != WIN) age_q[i] <= age_q[i] + 1'b1;
    if (alloc) begin
      addr_q[tail_q] <= st_addr;
      data_q[tail_q] <= st_data;
      mask_q[tail_q] <= st_mask;
      age_q[tail_q]  <= '0;
    end else if (hit) begin
      for (int b = 0; b < LANES; b++)
        if (st_mask[b]) data_q[yng][8*b +: 8] <= st_data[8*b +: 8];
      mask_q[yng] <= mask_q[yng] | st_mask;
    end
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CAP);

  a_r5_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && !cm_ready |=> cm_valid && $stable(cm_addr) && $stable(cm_data) && $stable(cm_mask));

  a_r1_merge_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !pop |=> cnt_q == $past(cnt_q));

  a_r3_head_advance: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> head_q == $past(head_q) + 1'b1);

  a_r10_empty_state: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == '0 |-> st_ready && !cm_valid);
endmodule

// File: tb/test_coalescing_store_buffer.sv
`timescale 1ns/1ps
module test_coalescing_store_buffer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, st_valid = 1'b0, cm_ready = 1'b1;
  logic [29:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic [3:0]  st_mask = '0;
  logic        st_ready, cm_valid, cm_full;
  logic [29:0] cm_addr;
  logic [31:0] cm_data;
  logic [3:0]  cm_mask;

  coalescing_store_buffer i_coalescing_store_buffer (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_mask(st_mask),
    .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_addr(cm_addr),
    .cm_data(cm_data), .cm_mask(cm_mask), .cm_full(cm_full));

  typedef struct { logic [29:0] a; logic [31:0] d; logic [3:0] m; int age; } ent_t;
  ent_t q[$];
  ent_t log_q[$];
  int n_cmp = 0, n_bad = 0;
  string tag = "R10";
  bit done = 0, rnd_on = 0;

  function automatic bit m_open();
    return q.size() > 0 && q[q.size()-1].age < 2;
  endfunction
  function automatic bit m_hit();
    return st_valid && m_open() && q[q.size()-1].a == st_addr;
  endfunction
  function automatic bit m_ready();
    return m_hit() || q.size() < 4;
  endfunction
  function automatic bit m_cv();
    return q.size() > 0 && !(q.size() == 1 && m_open());
  endfunction

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  always @(posedge clk) begin : model
    bit h, cv;
    int sz;
    ent_t e;
    if (!rst_n) q.delete();
    else begin
      h = m_hit(); cv = m_cv(); sz = q.size();
      if (cv && cm_ready) begin log_q.push_back(q[0]); void'(q.pop_front()); end
      foreach (q[i]) if (q[i].age < 2) begin e = q[i]; e.age++; q[i] = e; end
      if (h) begin
        e = q[q.size()-1];
        for (int b = 0; b < 4; b++) if (st_mask[b]) e.d[8*b +: 8] = st_data[8*b +: 8];
        e.m = e.m | st_mask;
        q[q.size()-1] = e;
      end else if (st_valid && sz < 4) begin
        e.a = st_addr; e.d = st_data; e.m = st_mask; e.age = 0;
        q.push_back(e);
      end
    end
  end

  always @(negedge clk) begin
    if (rnd_on) cm_ready = ($urandom % 4) != 0;
    #1;
    if (rst_n && !done) begin
      chk({tag, "/R4 st_ready"}, st_ready, m_ready());
      chk({tag, "/R9 cm_valid"}, cm_valid, m_cv());
      if (m_cv()) begin
        chk({tag, "/R3 cm_addr"}, cm_addr, q[0].a);
        chk({tag, "/R3 cm_data"}, cm_data, q[0].d);
        chk({tag, "/R3 cm_mask"}, cm_mask, q[0].m);
        chk({tag, "/R6 cm_full"}, cm_full, q[0].m == 4'hF);
      end
    end
  end

  task automatic put(logic [29:0] a, logic [31:0] d, logic [3:0] m);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d; st_mask = m;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); st_valid = 1'b0; end
  endtask

  task automatic drain();
    idle(1);
    cm_ready = 1'b1;
    while (q.size() != 0) @(negedge clk);
    idle(2);
  endtask

  task automatic expect_log(string r, int i, logic [29:0] a, logic [31:0] d, logic [3:0] m);
    if (i >= log_q.size()) chk({r, " commit missing"}, 0, 1);
    else begin
      chk({r, " log addr"}, log_q[i].a, a);
      chk({r, " log data"}, log_q[i].d, d);
      chk({r, " log mask"}, log_q[i].m, m);
    end
  endtask

  task automatic summary();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R3: actual hung expected drained");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset st_ready", st_ready, 1);
    chk("R10 reset cm_valid", cm_valid, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 and R6: three narrow stores build one full word
    tag = "R1"; log_q.delete();
    put(30'd5, 32'hAAAA_AA11, 4'b0001);
    put(30'd5, 32'hBBBB_22BB, 4'b0010);
    put(30'd5, 32'h4433_CCCC, 4'b1100);
    drain();
    chk("R1 one commit", log_q.size(), 1);
    expect_log("R1", 0, 30'd5, 32'h4433_2211, 4'hF);

    // R2: same lane written twice
    tag = "R2"; log_q.delete();
    put(30'd9, 32'h0000_00AA, 4'b0001);
    put(30'd9, 32'h0000_00BB, 4'b0001);
    drain();
    chk("R2 one commit", log_q.size(), 1);
    expect_log("R2", 0, 30'd9, 32'h0000_00BB, 4'b0001);

    // R7: same word after the window closed
    tag = "R7"; log_q.delete();
    put(30'd12, 32'h0000_0011, 4'b0001);
    idle(2);
    put(30'd12, 32'h0000_2200, 4'b0010);
    drain();
    chk("R7 two commits", log_q.size(), 2);
    expect_log("R7", 0, 30'd12, 32'h0000_0011, 4'b0001);
    expect_log("R7", 1, 30'd12, 32'h0000_2200, 4'b0010);

    // R8: a younger entry closes the older one
    tag = "R8"; log_q.delete();
    put(30'd20, 32'h0000_0011, 4'b0001);
    put(30'd21, 32'h0000_0022, 4'b0001);
    put(30'd20, 32'h0000_3300, 4'b0010);
    drain();
    chk("R8 three commits", log_q.size(), 3);
    expect_log("R8", 0, 30'd20, 32'h0000_0011, 4'b0001);
    expect_log("R8", 1, 30'd21, 32'h0000_0022, 4'b0001);
    expect_log("R8", 2, 30'd20, 32'h0000_3300, 4'b0010);

    // R4 and R5: array stalled, buffer fills
    tag = "R5"; log_q.delete();
    @(negedge clk); cm_ready = 1'b0;
    fork
      for (int k = 0; k < 6; k++) put(30'(30 + k), 32'h1111_1111 * (k + 1), 4'hF);
      begin
        repeat (10) @(negedge clk);
        #1;
        chk("R4 stall when full", st_ready, 0);
        chk("R5 offer held", cm_valid, 1);
        chk("R5 offer addr", cm_addr, 30'd30);
        @(negedge clk); cm_ready = 1'b1;
      end
    join
    drain();
    chk("R3 six commits", log_q.size(), 6);
    for (int k = 0; k < 6; k++) expect_log("R3 order", k, 30'(30 + k), 32'h1111_1111 * (k + 1), 4'hF);

    // R3: random mix of merges, stalls and commits
    tag = "R3"; log_q.delete();
    rnd_on = 1;
    repeat (500) begin
      if ($urandom % 4 == 0) idle(1);
      put(30'($urandom % 3), $urandom, 4'($urandom % 15) + 4'd1);
    end
    rnd_on = 0;
    drain();
    summary();
  end
endmodule